// File: doc/BRIEF.md
# Nonvolatile Store/Recall Command Sequencer

This block sits beside the read-access bus of a battery-free nonvolatile SRAM. It recognises a software command hidden in ordinary reads. A system clock samples chip-enable, write-enable and the address bus through two-flop synchronisers. Each chip-enable low pulse that is long enough counts as one step, and the step is taken when chip-enable rises again. Five fixed addresses, in a fixed order, followed by a sixth "code" address form the command. The code address chooses between copying the SRAM into the nonvolatile cells (STORE) and copying the cells back (RECALL).

Once a cycle starts, the block holds busy and the matching activity flag for a parameterised number of clock cycles. It keeps the data pins tri-stated for that whole time and ignores the bus. At the end it gives a one-cycle done pulse. A synchronised low-supply input cuts an active STORE short; the STORE then ends with a one-cycle abort pulse instead of done. The same input has no effect on a RECALL. When the supply-good input rises, the block starts an automatic RECALL of its own length.

Top module: `nv_seq_ctrl`

## Requirements
- R1: After reset, busy_o, store_o, recall_o, done_o, abort_o and dq_hiz_o are all 0, and they stay 0 while supply_good_i stays 0 and no command arrives.
- R2: Chip-enable pulses carrying ADDR1, ADDR2, ADDR3, ADDR4 and ADDR5 in that order, followed by a pulse carrying STORE_CODE, start a STORE (store_o = 1).
- R3: The sixth address alone picks the operation. STORE_CODE starts a STORE and RECALL_CODE starts a RECALL (recall_o = 1). Any other value starts nothing.
- R4: A step whose address is not the next expected one drops progress to zero, or to one step if that address equals ADDR1. A repeated or out-of-order address therefore breaks the command.
- R5: If write-enable is sampled low during any counted chip-enable low pulse, progress drops to zero and no cycle starts.
- R6: A chip-enable low pulse shorter than MIN_LOW clock samples is not a step. It neither advances nor breaks a command in progress.
- R7: A STORE keeps busy_o high for exactly STORE_CYCLES clocks, and a RECALL for exactly RECALL_CYCLES clocks. Each ends with done_o high for one cycle, in the cycle in which busy_o falls.
- R8: While busy_o is high, bus activity is ignored. A complete command issued during a cycle neither lengthens that cycle nor starts another one afterwards.
- R9: With store_inhibit_i high, an active STORE ends early with a one-cycle abort_o pulse and no done_o. A RECALL runs its full length and ends with done_o whatever the value of store_inhibit_i.
- R10: A rise of supply_good_i while the block is idle starts a RECALL that lasts exactly RESTORE_CYCLES clocks and ends with done_o.
- R11: dq_hiz_o is high in every cycle in which busy_o is high, and low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Memory chip-enable, active low, asynchronous |
| we_n_i | input | 1 | Memory write-enable, active low, asynchronous |
| addr_i | input | AW | Memory address bus |
| supply_good_i | input | 1 | Supply above switch threshold |
| store_inhibit_i | input | 1 | Low-supply indication that aborts a STORE |
| busy_o | output | 1 | A nonvolatile cycle is running |
| store_o | output | 1 | STORE in progress |
| recall_o | output | 1 | RECALL in progress (commanded or power-up) |
| done_o | output | 1 | One-cycle pulse when a cycle completes |
| abort_o | output | 1 | One-cycle pulse when a STORE is aborted |
| dq_hiz_o | output | 1 | Data pins held at high impedance |

## Verification
The bench builds the block with STORE_CYCLES = 60, RECALL_CYCLES = 12, RESTORE_CYCLES = 20 and MIN_LOW = 2, and keeps the default addresses. The short durations let it measure every cycle length exactly to the clock and compare the end flags within a few hundred clocks. The 60-cycle STORE is long enough to feed a complete RECALL command into the bus while the STORE runs. A MIN_LOW of 2 lets a single-cycle chip-enable glitch fall just under the width limit while a two-cycle pulse counts as a step.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } op_e;

    localparam int unsigned SEQ_LEN = 5;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvc_ce_filter.sv
module nvc_ce_filter #(
    parameter int unsigned AW      = 15,
    parameter int unsigned MIN_LOW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    output logic          step_o,
    output logic [AW-1:0] step_addr_o,
    output logic          step_we_ok_o
);
    localparam int unsigned LW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic          ce_m;
        logic          ce_s;
        logic          ce_p;
        logic          we_m;
        logic          we_s;
        logic [AW-1:0] a_m;
        logic [AW-1:0] a_s;
        logic [AW-1:0] a_lat;
        logic          we_bad;
        logic [LW-1:0] low_cnt;
        logic          step;
        logic [AW-1:0] step_addr;
        logic          step_ok;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.ce_m = ce_n_i;
        d.ce_s = q.ce_m;
        d.ce_p = q.ce_s;
        d.we_m = we_n_i;
        d.we_s = q.we_m;
        d.a_m  = addr_i;
        d.a_s  = q.a_m;
        d.step = 1'b0;
        if (!q.ce_s) begin
            d.a_lat = q.a_s;
            if (!q.we_s) begin
                d.we_bad = 1'b1;
            end
            if (q.low_cnt != LW'(MIN_LOW)) begin
                d.low_cnt = q.low_cnt + 1'b1;
            end
        end else if (!q.ce_p) begin
            d.step      = (q.low_cnt >= LW'(MIN_LOW));
            d.step_addr = q.a_lat;
            d.step_ok   = !q.we_bad;
            d.we_bad    = 1'b0;
            d.low_cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ce_m <= 1'b1;
            q.ce_s <= 1'b1;
            q.ce_p <= 1'b1;
            q.we_m <= 1'b1;
            q.we_s <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign step_o       = q.step;
    assign step_addr_o  = q.step_addr;
    assign step_we_ok_o = q.step_ok;

    // R6: a step is a single-cycle event per chip-enable rise
    p_step_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R6: the low-sample counter never passes its saturation point
    p_low_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.low_cnt <= LW'(MIN_LOW));

endmodule

// File: rtl/nvc_seq_detect.sv
module nvc_seq_detect #(
    parameter int unsigned   AW          = 15,
    parameter logic [AW-1:0] ADDR1       = 15'h1A5C,
    parameter logic [AW-1:0] ADDR2       = 15'h2C33,
    parameter logic [AW-1:0] ADDR3       = 15'h0F0F,
    parameter logic [AW-1:0] ADDR4       = 15'h3A96,
    parameter logic [AW-1:0] ADDR5       = 15'h1247,
    parameter logic [AW-1:0] STORE_CODE  = 15'h7E01,
    parameter logic [AW-1:0] RECALL_CODE = 15'h0C55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_ok_i,
    input  logic          busy_i,
    output logic          launch_store_o,
    output logic          launch_recall_o
);
    import nvc_pkg::*;

    localparam int unsigned   CNW = $clog2(SEQ_LEN + 1);
    localparam logic [AW-1:0] SEQ [SEQ_LEN] = '{ADDR1, ADDR2, ADDR3, ADDR4, ADDR5};

    typedef struct packed {
        logic [CNW-1:0] cnt;
    } det_t;

    det_t q, d;
    logic [SEQ_LEN-1:0] hit;

    generate
        for (genvar g = 0; g < SEQ_LEN; g++) begin : g_hit
            assign hit[g] = (addr_i == SEQ[g]);
        end
    endgenerate

    always_comb begin
        d               = q;
        launch_store_o  = 1'b0;
        launch_recall_o = 1'b0;
        if (busy_i) begin
            d.cnt = '0;
        end else if (step_i) begin
            if (!we_ok_i) begin
                d.cnt = '0;
            end else if (q.cnt == CNW'(SEQ_LEN)) begin
                if (addr_i == STORE_CODE) begin
                    launch_store_o = 1'b1;
                    d.cnt          = '0;
                end else if (addr_i == RECALL_CODE) begin
                    launch_recall_o = 1'b1;
                    d.cnt           = '0;
                end else begin
                    d.cnt = hit[0] ? CNW'(1) : '0;
                end
            end else if (hit[q.cnt]) begin
                d.cnt = q.cnt + 1'b1;
            end else begin
                d.cnt = hit[0] ? CNW'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: progress never exceeds the length of the address list
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNW'(SEQ_LEN));

    // R8: no launch request while a cycle is running
    p_no_launch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !(launch_store_o || launch_recall_o));

    // R8: a running cycle leaves no partial command behind
    p_busy_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (q.cnt == '0));

endmodule

// File: rtl/nvc_cycle_ctrl.sv
module nvc_cycle_ctrl #(
    parameter int unsigned STORE_CYCLES   = 1000000,
    parameter int unsigned RECALL_CYCLES  = 2000,
    parameter int unsigned RESTORE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_store_i,
    input  logic launch_recall_i,
    input  logic supply_good_i,
    input  logic store_inhibit_i,
    output logic busy_o,
    output logic store_o,
    output logic recall_o,
    output logic done_o,
    output logic abort_o,
    output logic dq_hiz_o
);
    import nvc_pkg::*;

    localparam int unsigned MAXD = max3(STORE_CYCLES, RECALL_CYCLES, RESTORE_CYCLES);
    localparam int unsigned CW   = $clog2(MAXD + 1);

    typedef struct packed {
        op_e           op;
        logic [CW-1:0] left;
        logic          sg_m;
        logic          sg_s;
        logic          sg_p;
        logic          si_m;
        logic          si_s;
        logic          done;
        logic          abort;
    } cyc_t;

    cyc_t q, d;
    logic sg_rise;

    assign sg_rise = q.sg_s && !q.sg_p;

    always_comb begin
        d       = q;
        d.sg_m  = supply_good_i;
        d.sg_s  = q.sg_m;
        d.sg_p  = q.sg_s;
        d.si_m  = store_inhibit_i;
        d.si_s  = q.si_m;
        d.done  = 1'b0;
        d.abort = 1'b0;
        unique case (q.op)
            OP_IDLE: begin
                if (sg_rise) begin
                    d.op   = OP_RECALL;
                    d.left = CW'(RESTORE_CYCLES - 1);
                end else if (launch_store_i) begin
                    d.op   = OP_STORE;
                    d.left = CW'(STORE_CYCLES - 1);
                end else if (launch_recall_i) begin
                    d.op   = OP_RECALL;
                    d.left = CW'(RECALL_CYCLES - 1);
                end
            end
            OP_STORE: begin
                if (q.si_s) begin
                    d.op    = OP_IDLE;
                    d.left  = '0;
                    d.abort = 1'b1;
                end else if (q.left == '0) begin
                    d.op   = OP_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                end
            end
            OP_RECALL: begin
                if (q.left == '0) begin
                    d.op   = OP_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                end
            end
            default: begin
                d.op   = OP_IDLE;
                d.left = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.op <= OP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.op != OP_IDLE);
    assign store_o  = (q.op == OP_STORE);
    assign recall_o = (q.op == OP_RECALL);
    assign done_o   = q.done;
    assign abort_o  = q.abort;
    assign dq_hiz_o = (q.op != OP_IDLE);

    // R7: done marks the cycle in which busy has just fallen
    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    // R7: a STORE ends with exactly one of done or abort
    p_store_end_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(store_o) && !store_o) |-> (done_o != abort_o));

    // R9: an abort only follows a STORE
    p_abort_from_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(store_o));

    // R9: a RECALL always finishes with done
    p_recall_completes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(recall_o) && !recall_o) |-> done_o);

endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl #(
    parameter int unsigned   AW             = 15,
    parameter int unsigned   MIN_LOW        = 2,
    parameter int unsigned   STORE_CYCLES   = 1000000,
    parameter int unsigned   RECALL_CYCLES  = 2000,
    parameter int unsigned   RESTORE_CYCLES = 2000,
    parameter logic [AW-1:0] ADDR1          = 15'h1A5C,
    parameter logic [AW-1:0] ADDR2          = 15'h2C33,
    parameter logic [AW-1:0] ADDR3          = 15'h0F0F,
    parameter logic [AW-1:0] ADDR4          = 15'h3A96,
    parameter logic [AW-1:0] ADDR5          = 15'h1247,
    parameter logic [AW-1:0] STORE_CODE     = 15'h7E01,
    parameter logic [AW-1:0] RECALL_CODE    = 15'h0C55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic          supply_good_i,
    input  logic          store_inhibit_i,
    output logic          busy_o,
    output logic          store_o,
    output logic          recall_o,
    output logic          done_o,
    output logic          abort_o,
    output logic          dq_hiz_o
);
    logic          step;
    logic [AW-1:0] step_addr;
    logic          step_we_ok;
    logic          launch_store;
    logic          launch_recall;

    nvc_ce_filter #(
        .AW      (AW),
        .MIN_LOW (MIN_LOW)
    ) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n_i       (ce_n_i),
        .we_n_i       (we_n_i),
        .addr_i       (addr_i),
        .step_o       (step),
        .step_addr_o  (step_addr),
        .step_we_ok_o (step_we_ok)
    );

    nvc_seq_detect #(
        .AW          (AW),
        .ADDR1       (ADDR1),
        .ADDR2       (ADDR2),
        .ADDR3       (ADDR3),
        .ADDR4       (ADDR4),
        .ADDR5       (ADDR5),
        .STORE_CODE  (STORE_CODE),
        .RECALL_CODE (RECALL_CODE)
    ) u_detect (
        .clk             (clk),
        .rst_n           (rst_n),
        .step_i          (step),
        .addr_i          (step_addr),
        .we_ok_i         (step_we_ok),
        .busy_i          (busy_o),
        .launch_store_o  (launch_store),
        .launch_recall_o (launch_recall)
    );

    nvc_cycle_ctrl #(
        .STORE_CYCLES   (STORE_CYCLES),
        .RECALL_CYCLES  (RECALL_CYCLES),
        .RESTORE_CYCLES (RESTORE_CYCLES)
    ) u_cycle (
        .clk             (clk),
        .rst_n           (rst_n),
        .launch_store_i  (launch_store),
        .launch_recall_i (launch_recall),
        .supply_good_i   (supply_good_i),
        .store_inhibit_i (store_inhibit_i),
        .busy_o          (busy_o),
        .store_o         (store_o),
        .recall_o        (recall_o),
        .done_o          (done_o),
        .abort_o         (abort_o),
        .dq_hiz_o        (dq_hiz_o)
    );

    // R2: a launch request only reaches an idle controller
    p_launch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_store || launch_recall) |-> !busy_o);

    // R3: the two launch requests never coincide
    p_launch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_store && launch_recall));

endmodule

// File: tb/nv_seq_ctrl_bench.sv
module nv_seq_ctrl_bench;
    localparam int unsigned   AW  = 15;
    localparam int unsigned   SC  = 60;
    localparam int unsigned   RC  = 12;
    localparam int unsigned   RSC = 20;
    localparam logic [AW-1:0] A1  = 15'h1A5C;
    localparam logic [AW-1:0] A2  = 15'h2C33;
    localparam logic [AW-1:0] A3  = 15'h0F0F;
    localparam logic [AW-1:0] A4  = 15'h3A96;
    localparam logic [AW-1:0] A5  = 15'h1247;
    localparam logic [AW-1:0] KS  = 15'h7E01;
    localparam logic [AW-1:0] KR  = 15'h0C55;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, sg = 1'b0, si = 1'b0;
    logic [AW-1:0] addr = '0;
    logic busy, st, rc, done, abrt, hiz;

    int total = 0, bad = 0;
    int run_len = 0, last_len = 0, done_cnt = 0, abort_cnt = 0, hiz_err = 0;
    int st_seen = 0, rc_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nv_seq_ctrl #(
        .AW (AW), .MIN_LOW (2), .STORE_CYCLES (SC), .RECALL_CYCLES (RC),
        .RESTORE_CYCLES (RSC)
    ) u_nv_seq_ctrl (
        .clk (clk), .rst_n (rst_n), .ce_n_i (ce_n), .we_n_i (we_n), .addr_i (addr),
        .supply_good_i (sg), .store_inhibit_i (si), .busy_o (busy), .store_o (st),
        .recall_o (rc), .done_o (done), .abort_o (abrt), .dq_hiz_o (hiz)
    );

    typedef struct packed {
        logic [AW-1:0] s1, s2, s3, s4, s5, s6;
        logic [5:0]    we_low;
        logic [1:0]    expect_op;   // 0 none, 1 store, 2 recall
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{A1, A2, A3, A4, A5, KS,       6'b000000, 2'd1},   // R2
        '{A1, A2, A3, A4, A5, KR,       6'b000000, 2'd2},   // R3
        '{A1, A2, A3, A4, A5, 15'h0001, 6'b000000, 2'd0},   // R3
        '{A1, A2, 15'h0123, A4, A5, KS, 6'b000000, 2'd0},   // R4
        '{A1, A2, A2, A3, A4, KS,       6'b000000, 2'd0},   // R4
        '{A1, A2, A3, A4, A5, KS,       6'b001000, 2'd0},   // R5
        '{A2, A3, A4, A5, KS, A1,       6'b000000, 2'd0},   // R4
        '{A1, A2, A3, A4, A5, KS,       6'b100000, 2'd0}    // R5
    };

    // background monitor: cycle lengths, end flags, tri-state tracking
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) run_len++;
            else if (run_len != 0) begin last_len = run_len; run_len = 0; end
            if (done) done_cnt++;
            if (abrt) abort_cnt++;
            if (st) st_seen++;
            if (rc) rc_seen++;
            if (busy != hiz) hiz_err++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [AW-1:0] a, input bit wl, input int low_len);
        @(negedge clk);
        addr = a; we_n = wl ? 1'b0 : 1'b1; ce_n = 1'b0;
        repeat (low_len) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mon();
        last_len = 0; done_cnt = 0; abort_cnt = 0; st_seen = 0; rc_seen = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [AW-1:0] code);
        pulse(A1, 0, 2); pulse(A2, 0, 2); pulse(A3, 0, 2);
        pulse(A4, 0, 2); pulse(A5, 0, 2); pulse(code, 0, 2);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R1: idle after reset with supply low
        chk("R1 busy", busy, 0);
        chk("R1 flags", {st, rc, done, abrt, hiz}, 0);

        // R10: power-up recall
        clear_mon();
        sg = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 recall active", rc, 1);
        wait_idle();
        chk("R10 length", last_len, RSC);
        chk("R10 done", done_cnt, 1);

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            clear_mon();
            pulse(15'h0000, 0, 2);
            pulse(VECS[v].s1, VECS[v].we_low[0], 2);
            pulse(VECS[v].s2, VECS[v].we_low[1], 2);
            pulse(VECS[v].s3, VECS[v].we_low[2], 2);
            pulse(VECS[v].s4, VECS[v].we_low[3], 2);
            pulse(VECS[v].s5, VECS[v].we_low[4], 2);
            pulse(VECS[v].s6, VECS[v].we_low[5], 2);
            repeat (2) @(negedge clk);
            chk($sformatf("R2/R3/R4/R5 vec%0d store", v), st, (VECS[v].expect_op == 2'd1) ? 1 : 0);
            chk($sformatf("R2/R3/R4/R5 vec%0d recall", v), rc, (VECS[v].expect_op == 2'd2) ? 1 : 0);
            wait_idle();
            chk($sformatf("R7 vec%0d done", v), done_cnt, (VECS[v].expect_op != 2'd0) ? 1 : 0);
        end

        // R7: exact STORE and RECALL lengths
        clear_mon();
        send_cmd(KS);
        wait_idle();
        chk("R7 store length", last_len, SC);
        chk("R7 store done", done_cnt, 1);
        chk("R7 store no abort", abort_cnt, 0);
        clear_mon();
        send_cmd(KR);
        wait_idle();
        chk("R7 recall length", last_len, RC);
        chk("R7 recall done", done_cnt, 1);

        // R6: short glitch in the middle is not a step
        clear_mon();
        pulse(A1, 0, 2); pulse(A2, 0, 2); pulse(A3, 0, 2);
        pulse(15'h0055, 0, 1);
        pulse(A4, 0, 2); pulse(A5, 0, 2); pulse(KS, 0, 2);
        repeat (2) @(negedge clk);
        chk("R6 glitch ignored, store starts", st, 1);
        wait_idle();

        // R4: repeated first address restarts at step one
        clear_mon();
        pulse(A1, 0, 2);
        send_cmd(KS);
        chk("R4 restart store", st, 1);
        wait_idle();

        // R8: a full command during a STORE is ignored
        clear_mon();
        send_cmd(KS);
        send_cmd(KR);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R8 store length", last_len, SC);
        chk("R8 no recall", rc_seen, 0);
        chk("R8 idle after", busy, 0);

        // R9: inhibit aborts STORE
        clear_mon();
        send_cmd(KS);
        repeat (10) @(negedge clk);
        si = 1'b1;
        wait_idle();
        chk("R9 abort pulse", abort_cnt, 1);
        chk("R9 no done", done_cnt, 0);
        chk("R9 cut short", (last_len < SC) ? 1 : 0, 1);
        // R9: inhibit does not touch RECALL
        clear_mon();
        send_cmd(KR);
        wait_idle();
        chk("R9 recall length", last_len, RC);
        chk("R9 recall done", done_cnt, 1);
        chk("R9 recall no abort", abort_cnt, 0);
        si = 1'b0;

        // R11: tri-state tracked busy throughout
        chk("R11 hiz mismatches", hiz_err, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule